// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block forms the word that a read returns while the embedded program or erase engine is working. The operation controller feeds it level flags: a program is running, an erase is running, or an erase is suspended together with the id of the suspended sector. It also supplies bit 7 of the last word loaded for programming. Reads arrive as requests carrying a sector id and the array word fetched for that address. Each accepted request gets one response word. In that word three bit positions may be replaced by completion indicators. Bit 7 is the polling bit. Bit 6 toggles on every read during an operation. Bit 2 toggles on accesses to the suspended sector. When no indicator applies, the array word passes through unchanged.

A separate registered output requests the shared ready/busy line to be pulled low for as long as an operation runs. The value 1 means drive low and 0 means release to high-Z, so several devices can share the line. Requests and responses use valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the one-entry response slot is empty or is being drained in the same cycle. A response is held unchanged while `resp_valid` is high and `resp_ready` is low. Program accesses to a sector are signalled by a one-cycle strobe with no handshake.

Top module: `sbg_status_gen`

## Requirements
- R1: A read accepted while `prog_busy` is 1 returns the inverse of `last_load_b7` on bit 7 of its response.
- R2: A read accepted while `erase_busy` is 1 and `prog_busy` is 0 returns 0 on bit 7.
- R3: While either busy flag is 1, bit 6 of the first accepted read since both flags were last 0 is 0, and each later accepted read returns the inverse of the bit 6 that the previous read returned.
- R4: While `erase_susp` is 1, an accepted read whose `req_sector` equals `susp_sector` returns the suspended-sector toggle on bit 2. This toggle is 0 when suspension begins. The read then inverts the toggle. A `pgm_stb` whose `pgm_sector` equals `susp_sector` also inverts it.
- R5: A matching read and a matching `pgm_stb` in the same cycle count as two accesses. The toggle ends the cycle unchanged, and the read returns the value it had before that cycle.
- R6: A `pgm_stb` to any other sector leaves the suspended-sector toggle unchanged. A read of any other sector during suspension, with no operation running, returns the array word with bit 2 untouched.
- R7: `rb_pull_low` is 0 after reset. After each clock it equals the OR of `prog_busy` and `erase_busy` sampled at that clock.
- R8: With both busy flags 0 and no suspended-sector hit, the response equals the `array_data` presented with the request.
- R9: In a status response, every bit other than 7, 6 and 2 equals the corresponding bit of `array_data`.
- R10: `req_ready` equals NOT `resp_valid` OR `resp_ready`. The response appears in the cycle after acceptance. A stalled response keeps its data. A request presented while `req_ready` is 0 is not accepted and advances no toggle.
- R11: After reset `resp_valid` and `rb_pull_low` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_busy | input | 1 | Embedded program running |
| erase_busy | input | 1 | Chip or sector erase running |
| erase_susp | input | 1 | An erase is suspended |
| susp_sector | input | SW | Id of the suspended sector |
| last_load_b7 | input | 1 | Bit 7 of the last word loaded for programming |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted this cycle if valid |
| req_sector | input | SW | Sector targeted by the read |
| array_data | input | DW | Array word for the read address |
| pgm_stb | input | 1 | One-cycle program access strobe |
| pgm_sector | input | SW | Sector targeted by the program access |
| resp_valid | output | 1 | Response word valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | DW | Status or array word |
| rb_pull_low | output | 1 | 1 drives the ready/busy line low, 0 releases it |

## Verification
The two functions that can land in the same cycle are a read that hits the suspended sector and a program strobe that hits the same sector. Both move the bit 2 toggle. The bench drives both in one cycle after leaving the toggle at a known value. It then judges two things: that read returns the old value, and a following read returns the same value again, showing the two flips cancelled. A second overlap is a new request presented while the response slot is stalled. This is judged by the held data and by the later acceptance, which returns the new word.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  // Bit positions the host software decodes; fixed by behaviour.
  localparam int POLL_BIT = 7;
  localparam int RUN_TOG_BIT = 6;
  localparam int SUSP_TOG_BIT = 2;
  localparam int MIN_DW = POLL_BIT + 1;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_PROG  = 2'd1,
    SRC_ERASE = 2'd2
  } poll_src_e;
endpackage

// File: rtl/sbg_toggle_track.sv
module sbg_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic op_active,
  input  logic susp_active,
  input  logic rd_fire,
  input  logic rd_hit,
  input  logic pgm_hit,
  output logic run_tog,
  output logic susp_tog
);
  logic susp_flip;

  // Two hits in one cycle cancel out.
  assign susp_flip = rd_hit ^ pgm_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_tog  <= 1'b0;
      susp_tog <= 1'b0;
    end else begin
      if (!op_active)   run_tog <= 1'b0;
      else if (rd_fire) run_tog <= ~run_tog;

      if (!susp_active)   susp_tog <= 1'b0;
      else if (susp_flip) susp_tog <= ~susp_tog;
    end
  end
endmodule

// File: rtl/sbg_word_former.sv
module sbg_word_former
  import sbg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] array_data,
  input  poll_src_e     poll_src,
  input  logic          last_load_b7,
  input  logic          run_tog,
  input  logic          susp_tog,
  input  logic          rd_hit,
  output logic [DW-1:0] word
);
  logic status_run;
  assign status_run = (poll_src != SRC_ARRAY);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      always_comb begin
        unique case (poll_src)
          SRC_PROG:  word[b] = ~last_load_b7;
          SRC_ERASE: word[b] = 1'b0;
          default:   word[b] = array_data[b];
        endcase
      end
    end else if (b == RUN_TOG_BIT) begin : g_run
      assign word[b] = status_run ? run_tog : array_data[b];
    end else if (b == SUSP_TOG_BIT) begin : g_susp
      assign word[b] = rd_hit ? susp_tog : array_data[b];
    end else begin : g_pass
      assign word[b] = array_data[b];
    end
  end
endmodule

// File: rtl/sbg_resp_slot.sv
module sbg_resp_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sbg_status_gen.sv
module sbg_status_gen
  import sbg_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_busy,
  input  logic          erase_busy,
  input  logic          erase_susp,
  input  logic [SW-1:0] susp_sector,
  input  logic          last_load_b7,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_sector,
  input  logic [DW-1:0] array_data,
  input  logic          pgm_stb,
  input  logic [SW-1:0] pgm_sector,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [DW-1:0] resp_data,
  output logic          rb_pull_low
);
  logic          op_active, rd_fire, rd_hit, pgm_hit;
  logic          run_tog, susp_tog;
  poll_src_e     poll_src;
  logic [DW-1:0] word;

  assign op_active = prog_busy || erase_busy;
  assign rd_fire   = req_valid && req_ready;
  assign rd_hit    = rd_fire && erase_susp && (req_sector == susp_sector);
  assign pgm_hit   = pgm_stb && erase_susp && (pgm_sector == susp_sector);

  always_comb begin
    if (prog_busy)       poll_src = SRC_PROG;
    else if (erase_busy) poll_src = SRC_ERASE;
    else                 poll_src = SRC_ARRAY;
  end

  sbg_toggle_track u_tog (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_active   (op_active),
    .susp_active (erase_susp),
    .rd_fire     (rd_fire),
    .rd_hit      (rd_hit),
    .pgm_hit     (pgm_hit),
    .run_tog     (run_tog),
    .susp_tog    (susp_tog)
  );

  sbg_word_former #(.DW(DW)) u_form (
    .array_data   (array_data),
    .poll_src     (poll_src),
    .last_load_b7 (last_load_b7),
    .run_tog      (run_tog),
    .susp_tog     (susp_tog),
    .rd_hit       (rd_hit),
    .word         (word)
  );

  sbg_resp_slot #(.DW(DW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (word),
    .out_valid (resp_valid),
    .out_ready (resp_ready),
    .out_data  (resp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rb_pull_low <= 1'b0;
    else        rb_pull_low <= op_active;
  end
endmodule

// File: rtl/sbg_status_chk.sv
module sbg_status_chk #(
  parameter int DW = 16,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_busy,
  input logic          erase_busy,
  input logic          erase_susp,
  input logic [SW-1:0] susp_sector,
  input logic          last_load_b7,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_sector,
  input logic [DW-1:0] array_data,
  input logic          resp_valid,
  input logic          resp_ready,
  input logic [DW-1:0] resp_data,
  input logic          rb_pull_low
);
  logic fire, busy, run_ok, pend, prev6, prev6_v;
  assign fire = req_valid && req_ready;
  assign busy = prog_busy || erase_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_ok  <= 1'b0;
      pend    <= 1'b0;
      prev6   <= 1'b0;
      prev6_v <= 1'b0;
    end else begin
      run_ok <= 1'b1;
      pend   <= fire && busy;
      if (!busy) prev6_v <= 1'b0;
      else if (pend) begin
        prev6   <= resp_data[6];
        prev6_v <= 1'b1;
      end
    end
  end

  AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    fire && prog_busy |=> resp_data[7] == !$past(last_load_b7)); // R1
  AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && erase_busy && !prog_busy |=> !resp_data[7]); // R2
  AST_TOG_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    pend && prev6_v |-> resp_data[6] != prev6); // R3
  AST_RB_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> rb_pull_low == $past(busy)); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !busy && !(erase_susp && req_sector == susp_sector)
    |=> resp_data == $past(array_data)); // R8
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data)); // R10
endmodule

bind sbg_status_gen sbg_status_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .prog_busy    (prog_busy),
  .erase_busy   (erase_busy),
  .erase_susp   (erase_susp),
  .susp_sector  (susp_sector),
  .last_load_b7 (last_load_b7),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_sector   (req_sector),
  .array_data   (array_data),
  .resp_valid   (resp_valid),
  .resp_ready   (resp_ready),
  .resp_data    (resp_data),
  .rb_pull_low  (rb_pull_low)
);

// File: tb/test_sbg_status_gen.sv
`timescale 1ns/1ps
module test_sbg_status_gen;
  localparam int DW = 16;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_busy = 1'b0, erase_busy = 1'b0, erase_susp = 1'b0;
  logic [SW-1:0] susp_sector = '0, req_sector = '0, pgm_sector = '0;
  logic last_load_b7 = 1'b0;
  logic req_valid = 1'b0, resp_ready = 1'b1, pgm_stb = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic req_ready, resp_valid, rb_pull_low;
  logic [DW-1:0] resp_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sbg_status_gen #(.DW(DW), .SW(SW)) i_sbg_status_gen (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
    .erase_susp(erase_susp), .susp_sector(susp_sector), .last_load_b7(last_load_b7),
    .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
    .array_data(array_data), .pgm_stb(pgm_stb), .pgm_sector(pgm_sector),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .rb_pull_low(rb_pull_low)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One read, optionally with a program strobe in the same cycle.
  task automatic rd(input logic [SW-1:0] sec, input logic [DW-1:0] arr,
                    input bit with_pgm, input logic [SW-1:0] psec,
                    output logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_sector = sec; array_data = arr;
    pgm_stb = with_pgm; pgm_sector = psec;
    @(negedge clk);
    req_valid = 1'b0; pgm_stb = 1'b0;
    chk(resp_valid, "R10 valid after accept", {15'd0, resp_valid}, 16'd1);
    d = resp_data;
  endtask

  task automatic pgm_only(input logic [SW-1:0] psec);
    @(negedge clk);
    pgm_stb = 1'b1; pgm_sector = psec;
    @(negedge clk);
    pgm_stb = 1'b0;
  endtask

  task automatic t_reset;
    chk(!resp_valid, "R11 resp_valid", {15'd0, resp_valid}, 16'd0);
    chk(!rb_pull_low, "R11 rb_pull_low", {15'd0, rb_pull_low}, 16'd0);
    chk(req_ready, "R11 req_ready", {15'd0, req_ready}, 16'd1);
  endtask

  task automatic t_pass;
    logic [DW-1:0] d;
    rd(6'd1, 16'h1234, 1'b0, 6'd0, d);
    chk(d == 16'h1234, "R8 idle pass-through", d, 16'h1234);
  endtask

  task automatic t_program;
    logic [DW-1:0] d;
    @(negedge clk);
    prog_busy = 1'b1; last_load_b7 = 1'b1;
    @(negedge clk);
    chk(rb_pull_low, "R7 low during program", {15'd0, rb_pull_low}, 16'd1);
    rd(6'd1, 16'hFFFF, 1'b0, 6'd0, d);
    chk(d == 16'hFF3F, "R1 R3 R9 first program read", d, 16'hFF3F);
    rd(6'd1, 16'hFFFF, 1'b0, 6'd0, d);
    chk(d == 16'hFF7F, "R3 second read toggles", d, 16'hFF7F);
    last_load_b7 = 1'b0;
    rd(6'd1, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0080, "R1 R3 inverse of loaded bit", d, 16'h0080);
    @(negedge clk);
    prog_busy = 1'b0;
    @(negedge clk);
    chk(!rb_pull_low, "R7 released after program", {15'd0, rb_pull_low}, 16'd0);
    rd(6'd1, 16'hABCD, 1'b0, 6'd0, d);
    chk(d == 16'hABCD, "R8 true data after completion", d, 16'hABCD);
  endtask

  task automatic t_erase;
    logic [DW-1:0] d;
    @(negedge clk);
    erase_busy = 1'b1; last_load_b7 = 1'b0;
    rd(6'd2, 16'hFFFF, 1'b0, 6'd0, d);
    chk(d == 16'hFF3F, "R2 R3 first erase read", d, 16'hFF3F);
    rd(6'd2, 16'hFFFF, 1'b0, 6'd0, d);
    chk(d == 16'hFF7F, "R2 R3 second erase read", d, 16'hFF7F);
    chk(rb_pull_low, "R7 low during erase", {15'd0, rb_pull_low}, 16'd1);
  endtask

  task automatic t_suspend;
    logic [DW-1:0] d;
    @(negedge clk);
    erase_busy = 1'b0; erase_susp = 1'b1; susp_sector = 6'd5;
    rd(6'd5, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0000, "R4 first hit reads 0", d, 16'h0000);
    rd(6'd5, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0004, "R4 second hit toggles", d, 16'h0004);
    rd(6'd3, 16'hFFFF, 1'b0, 6'd0, d);
    chk(d == 16'hFFFF, "R6 other sector untouched", d, 16'hFFFF);
    rd(6'd5, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0000, "R6 other read no flip", d, 16'h0000);
    pgm_only(6'd5);
    rd(6'd5, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0000, "R4 program hit flips", d, 16'h0000);
    pgm_only(6'd2);
    rd(6'd5, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0004, "R6 other program no flip", d, 16'h0004);
    rd(6'd5, 16'h0000, 1'b1, 6'd5, d);
    chk(d == 16'h0000, "R5 same-cycle read returns old", d, 16'h0000);
    rd(6'd5, 16'h0000, 1'b0, 6'd0, d);
    chk(d == 16'h0000, "R5 two flips cancel", d, 16'h0000);
    @(negedge clk);
    erase_susp = 1'b0;
  endtask

  task automatic t_stall;
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; array_data = 16'h1111; req_sector = 6'd1;
    @(negedge clk);
    array_data = 16'h2222;
    chk(resp_data == 16'h1111, "R10 first word", resp_data, 16'h1111);
    chk(!req_ready, "R10 not ready when stalled", {15'd0, req_ready}, 16'd0);
    @(negedge clk);
    chk(resp_valid && resp_data == 16'h1111, "R10 held while stalled", resp_data, 16'h1111);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid && resp_data == 16'h2222, "R10 second accepted after drain",
        resp_data, 16'h2222);
    @(negedge clk);
    chk(!resp_valid, "R10 drained", {15'd0, resp_valid}, 16'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_program();
    t_erase();
    t_suspend();
    t_stall();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule